// File: doc/BRIEF.md
# Two-Channel PWM with Shadowed Register Updates

This block generates two independent pulse-width-modulated outputs under control of a small word-addressed register bus. Every channel owns a control word, a clock prescaler, a period length and an active-time (duty) value. The prescaler slows the counting rate, the period value sets how many prescaled ticks one output cycle spans, and the duty value sets how many of those ticks the output spends in its active level. Polarity can be flipped, and a running channel can be stopped either at once or at the end of the cycle in progress.

A bus write never reaches the counters directly. The value lands in a shadow register, and a pending flag for that register stays raised for a fixed synchronisation delay. Software polls a shared status word until the flags it cares about have dropped. A running channel picks up new prescaler, period and duty values only at the end of an output cycle, and only when automatic reload is on. Two control bits can instead push a new prescaler or period into the running counters without waiting. While a channel is stopped, its counters always follow the latest absorbed values.

The address map has room for four channels, but only two are built. The two empty slots read as zero, and writes to them are dropped.

Top module: `pwm2_shadowed`

## Requirements
- R1: Bus addresses are word indices. Channel n (n = 0 or 1) uses words 4n+0 for control (6 bits), 4n+1 for the prescaler (10 bits), 4n+2 for the period (12 bits) and 4n+3 for the duty (12 bits). A read returns the last value written there, with the unused upper bits at zero.
- R2: Words 8 to 15 belong to the two unbuilt channel slots. They read as zero, and writes to them change nothing, not even the status word. Word 16 is the read-only status word. Words 17 to 31 read as zero.
- R3: In the status word, channel n owns bits 8n+0 (control pending), 8n+1 (prescaler pending), 8n+2 (period pending) and 8n+3 (duty pending). A bit reads 1 from the clock edge that performs the write through the next two edges. It reads 0 from the third edge after the write onward.
- R4: A running channel repeats an output cycle of (P+1)·(N+1) clocks, where P is the prescaler and N is the period. The output is active for the first D·(P+1) clocks of each cycle, where D is the duty and 0 < D ≤ N.
- R5: Control bit 1 inverts the output. With it set, the active level is 0 and the idle level is 1. The idle level applies whenever the channel is not running.
- R6: A duty of 0 holds the output at its inactive level. A duty greater than the period holds it at its active level.
- R7: Control bit 2 enables automatic reload. While a channel runs, newly absorbed prescaler, period and duty values take effect at the next cycle end only when this bit is set. Otherwise the running values stay unchanged.
- R8: Control bit 4 loads the absorbed prescaler into the running counter, and bit 5 loads the absorbed period. Either load happens one clock after the control write is absorbed, without waiting for the cycle end.
- R9: Control bit 0 enables the channel. When it is cleared with control bit 3 at 0, the current output cycle runs to its end before the output goes idle. When it is cleared with bit 3 at 1, the output goes idle on the clock after the control write is absorbed.
- R10: After reset, every register reads 0, the status word reads 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the bus and the counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 5 | Word address for reads and writes |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data, a combinational function of bus_addr |
| pwm_out | output | 2 | One modulated output per channel |

## Verification
The bench steps through the pending-flag window one edge at a time. A countdown that is one cycle too short or too long shows up as a status word that clears early or late. It writes to the empty slots and to the status word. A decoder that drops the upper slot bit would alias those writes onto channel 0 and raise a pending flag. Running values are changed with reload off, then with a forced period load, and then with reload on. A design that loads at the wrong time shows a wrong high or low length in the next measured cycle. Stopping is checked a few clocks into a long active phase: a deferred stop must stay active there, and an immediate stop must already be idle.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

  // Control word bit positions (software-visible, decoded by the channel core)
  localparam int CTRL_W        = 6;
  localparam int CB_ENABLE     = 0;
  localparam int CB_INVERT     = 1;
  localparam int CB_AUTOLOAD   = 2;
  localparam int CB_STOP_NOW   = 3;
  localparam int CB_FORCE_PRE  = 4;
  localparam int CB_FORCE_PER  = 5;

  // Register select: low two bits of the word address inside a channel slot
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PRE  = 2'd1,
    SEL_PER  = 2'd2,
    SEL_DUTY = 2'd3
  } reg_sel_e;

  // Counter has reached (or passed) its limit
  function automatic logic reached(input logic [15:0] cnt, input logic [15:0] lim);
    return cnt >= lim;
  endfunction

  // Position inside the cycle lies in the active window
  function automatic logic in_active(input logic [15:0] pos, input logic [15:0] duty);
    return pos < duty;
  endfunction

endpackage

// File: rtl/pwm_sync_reg.sv
module pwm_sync_reg #(
  parameter int W   = 12,
  parameter int DLY = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow,
  output logic [W-1:0] synced,
  output logic         pending
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] left;
  logic          absorb;

  assign pending = (left != '0);
  assign absorb  = (left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      synced <= '0;
      left   <= '0;
    end else begin
      if (absorb) synced <= shadow;
      if (wr) begin
        shadow <= wdata;
        left   <= CW'(DLY);
      end else if (pending) begin
        left <= left - CW'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm2_pkg::*;
#(
  parameter int PRE_W = 10,
  parameter int PER_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_s,
  input  logic              ctrl_pend,
  input  logic [PRE_W-1:0]  pre_s,
  input  logic [PER_W-1:0]  per_s,
  input  logic [PER_W-1:0]  duty_s,
  output logic              pwm_out,
  output logic              running,
  output logic              wrap,
  output logic              force_per,
  output logic [PER_W-1:0]  act_per
);
  logic [PRE_W-1:0] act_pre, pre_cnt;
  logic [PER_W-1:0] act_duty, per_cnt;
  logic             pend_q, force_pre, tick, en, inv, auto, stop_now, ctrl_landed;

  assign en       = ctrl_s[CB_ENABLE];
  assign inv      = ctrl_s[CB_INVERT];
  assign auto     = ctrl_s[CB_AUTOLOAD];
  assign stop_now = ctrl_s[CB_STOP_NOW];

  // A control write has just been absorbed: its pending flag fell last cycle
  assign ctrl_landed = pend_q && !ctrl_pend;
  assign force_pre   = ctrl_landed && ctrl_s[CB_FORCE_PRE];
  assign force_per   = ctrl_landed && ctrl_s[CB_FORCE_PER];

  assign tick = reached(16'(pre_cnt), 16'(act_pre));
  assign wrap = running && tick && reached(16'(per_cnt), 16'(act_per));

  assign pwm_out = running ? (in_active(16'(per_cnt), 16'(act_duty)) ^ inv) : inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      pre_cnt  <= '0;
      per_cnt  <= '0;
      act_pre  <= '0;
      act_per  <= '0;
      act_duty <= '0;
      pend_q   <= 1'b0;
    end else begin
      pend_q <= ctrl_pend;
      if (!running) begin
        pre_cnt  <= '0;
        per_cnt  <= '0;
        act_pre  <= pre_s;
        act_per  <= per_s;
        act_duty <= duty_s;
        running  <= en;
      end else begin
        if (!en && stop_now) begin
          running <= 1'b0;
          pre_cnt <= '0;
          per_cnt <= '0;
        end else if (wrap) begin
          pre_cnt <= '0;
          per_cnt <= '0;
          running <= en;
          if (auto) begin
            act_pre  <= pre_s;
            act_per  <= per_s;
            act_duty <= duty_s;
          end
        end else if (tick) begin
          pre_cnt <= '0;
          per_cnt <= per_cnt + PER_W'(1);
        end else begin
          pre_cnt <= pre_cnt + PRE_W'(1);
        end
        if (force_pre) act_pre <= pre_s;
        if (force_per) act_per <= per_s;
      end
    end
  end
endmodule

// File: rtl/pwm2_shadowed.sv
module pwm2_shadowed
  import pwm2_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int PRE_W    = 10,
  parameter int PER_W    = 12,
  parameter int SYNC_DLY = 3,
  localparam int STAT_W  = 8 * NUM_CH - 4,
  localparam int DATA_W  = (STAT_W > PER_W) ? STAT_W : PER_W,
  localparam int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam logic [ADDR_W-1:0] STATUS_WORD = ADDR_W'(16);

  // Address decode
  logic       in_slots, is_status;
  logic [1:0] slot;
  reg_sel_e   sel;

  assign in_slots  = !bus_addr[4];
  assign slot      = bus_addr[3:2];
  assign sel       = reg_sel_e'(bus_addr[1:0]);
  assign is_status = (bus_addr == STATUS_WORD);

  // Per-channel shadow / synced values and observation wires
  logic [CTRL_W-1:0] ctrl_sh [NUM_CH];
  logic [CTRL_W-1:0] ctrl_s  [NUM_CH];
  logic [PRE_W-1:0]  pre_sh  [NUM_CH];
  logic [PRE_W-1:0]  pre_s   [NUM_CH];
  logic [PER_W-1:0]  per_sh  [NUM_CH];
  logic [PER_W-1:0]  per_s   [NUM_CH];
  logic [PER_W-1:0]  duty_sh [NUM_CH];
  logic [PER_W-1:0]  duty_s  [NUM_CH];
  logic [PER_W-1:0]  ch_act_per [NUM_CH];
  logic [NUM_CH-1:0] pend_ctrl, pend_pre, pend_per, pend_duty;
  logic [NUM_CH-1:0] ch_running, ch_wrap, ch_force_per, ch_en_s, ch_stop_s;
  logic [DATA_W-1:0] status_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_we && in_slots && (slot == 2'(c));

    pwm_sync_reg #(.W(CTRL_W), .DLY(SYNC_DLY)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(hit && sel == SEL_CTRL),
      .wdata(bus_wdata[CTRL_W-1:0]), .shadow(ctrl_sh[c]), .synced(ctrl_s[c]),
      .pending(pend_ctrl[c]));

    pwm_sync_reg #(.W(PRE_W), .DLY(SYNC_DLY)) u_pre (
      .clk(clk), .rst_n(rst_n), .wr(hit && sel == SEL_PRE),
      .wdata(bus_wdata[PRE_W-1:0]), .shadow(pre_sh[c]), .synced(pre_s[c]),
      .pending(pend_pre[c]));

    pwm_sync_reg #(.W(PER_W), .DLY(SYNC_DLY)) u_per (
      .clk(clk), .rst_n(rst_n), .wr(hit && sel == SEL_PER),
      .wdata(bus_wdata[PER_W-1:0]), .shadow(per_sh[c]), .synced(per_s[c]),
      .pending(pend_per[c]));

    pwm_sync_reg #(.W(PER_W), .DLY(SYNC_DLY)) u_duty (
      .clk(clk), .rst_n(rst_n), .wr(hit && sel == SEL_DUTY),
      .wdata(bus_wdata[PER_W-1:0]), .shadow(duty_sh[c]), .synced(duty_s[c]),
      .pending(pend_duty[c]));

    pwm_chan_core #(.PRE_W(PRE_W), .PER_W(PER_W)) u_core (
      .clk(clk), .rst_n(rst_n), .ctrl_s(ctrl_s[c]), .ctrl_pend(pend_ctrl[c]),
      .pre_s(pre_s[c]), .per_s(per_s[c]), .duty_s(duty_s[c]),
      .pwm_out(pwm_out[c]), .running(ch_running[c]), .wrap(ch_wrap[c]),
      .force_per(ch_force_per[c]), .act_per(ch_act_per[c]));

    assign ch_en_s[c]   = ctrl_s[c][CB_ENABLE];
    assign ch_stop_s[c] = ctrl_s[c][CB_STOP_NOW];
  end

  // Status word: four pending flags per channel, one byte lane each
  always_comb begin
    status_vec = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      status_vec[8*c +: 4] = {pend_duty[c], pend_per[c], pend_pre[c], pend_ctrl[c]};
    end
  end

  // Read mux: shadows are what software sees
  always_comb begin
    bus_rdata = '0;
    if (is_status) begin
      bus_rdata = status_vec;
    end else if (in_slots) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (slot == 2'(c)) begin
          case (sel)
            SEL_CTRL: bus_rdata = DATA_W'(ctrl_sh[c]);
            SEL_PRE:  bus_rdata = DATA_W'(pre_sh[c]);
            SEL_PER:  bus_rdata = DATA_W'(per_sh[c]);
            default:  bus_rdata = DATA_W'(duty_sh[c]);
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pwm2_shadowed_chk.sv
module pwm2_shadowed_chk #(
  parameter int NUM_CH = 2,
  parameter int PER_W  = 12,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] status_vec,
  input logic [NUM_CH-1:0] running,
  input logic [NUM_CH-1:0] wrap,
  input logic [NUM_CH-1:0] en_s,
  input logic [NUM_CH-1:0] stop_s,
  input logic [NUM_CH-1:0] force_per,
  input logic [PER_W-1:0]  act_per [NUM_CH]
);
  AST_EMPTY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_addr[4] && (32'(bus_addr[3:2]) >= NUM_CH)) |-> (bus_rdata == '0)); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_PEND_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(4*c + 2)) |=> status_vec[8*c+2]); // R3

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_vec[8*c]) |=> status_vec[8*c]); // R3

    AST_IMM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (running[c] && !en_s[c] && stop_s[c]) |=> !running[c]); // R9

    AST_DEFER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (running[c] && !en_s[c] && !stop_s[c] && !wrap[c]) |=> running[c]); // R9

    AST_NO_MIDCYCLE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (running[c] && !wrap[c] && !force_per[c]) |=> $stable(act_per[c])); // R7
  end
endmodule

bind pwm2_shadowed pwm2_shadowed_chk #(
  .NUM_CH(NUM_CH), .PER_W(PER_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .status_vec(status_vec), .running(ch_running),
  .wrap(ch_wrap), .en_s(ch_en_s), .stop_s(ch_stop_s),
  .force_per(ch_force_per), .act_per(ch_act_per)
);

// File: tb/pwm2_shadowed_test.sv
`timescale 1ns/1ps
module pwm2_shadowed_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [11:0] bus_wdata = '0;
  logic [11:0] bus_rdata;
  logic [1:0]  pwm_out;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [4:0] STAT = 5'd16;

  // {ch, inv, pre[9:0], per[11:0], duty[11:0], exp_hi[15:0], exp_lo[15:0]}
  localparam int NV = 5;
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, 1'b0, 10'd0, 12'd9, 12'd3, 16'd3,  16'd7},
    {1'b0, 1'b1, 10'd2, 12'd7, 12'd5, 16'd15, 16'd9},
    {1'b1, 1'b0, 10'd1, 12'd4, 12'd1, 16'd2,  16'd8},
    {1'b1, 1'b1, 10'd3, 12'd5, 12'd5, 16'd20, 16'd4},
    {1'b0, 1'b0, 10'd0, 12'd1, 12'd1, 16'd1,  16'd1}
  };

  always #2.5 clk = ~clk;

  pwm2_shadowed uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic logic [4:0] wa(input int ch, input int r);
    return 5'(ch * 4 + r);
  endfunction

  function automatic logic act(input int ch, input logic inv);
    return pwm_out[ch] ^ inv;
  endfunction

  task automatic chk(input logic ok, input string req, input int actual, input int expected);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [11:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [11:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic poll();
    logic [11:0] d;
    d = '1;
    for (int g = 0; g < 100; g++) begin
      rd(STAT, d);
      if (d == '0) break;
      @(negedge clk);
    end
    if (d != '0) chk(1'b0, "R3 poll timeout", int'(d), 0);
  endtask

  task automatic wait_rise(input int ch, input logic inv);
    int g;
    g = 0;
    while (act(ch, inv) && g < 3000) begin @(negedge clk); g++; end
    while (!act(ch, inv) && g < 6000) begin @(negedge clk); g++; end
  endtask

  task automatic measure(input int ch, input logic inv, output int hi, output int lo);
    wait_rise(ch, inv);
    hi = 0; lo = 0;
    while (act(ch, inv) && hi < 5000) begin hi++; @(negedge clk); end
    while (!act(ch, inv) && lo < 5000) begin lo++; @(negedge clk); end
  endtask

  task automatic count_active(input int ch, input int n, output int ones);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) ones++;
    end
  endtask

  initial begin
    logic [11:0] d;
    int hi, lo, ones;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk(pwm_out == 2'b00, "R10 outputs after reset", int'(pwm_out), 0);
    rd(STAT, d);        chk(d == 12'h000, "R10 status after reset", int'(d), 0);
    rd(wa(1, 2), d);    chk(d == 12'h000, "R10 period ch1 after reset", int'(d), 0);

    // R3: pending window on ch0 period (bit 2)
    wr(wa(0, 2), 12'd5);
    rd(STAT, d);        chk(d == 12'h004, "R3 pending right after write", int'(d), 4);
    @(negedge clk); @(negedge clk);
    rd(STAT, d);        chk(d == 12'h004, "R3 pending two edges later", int'(d), 4);
    @(negedge clk);
    rd(STAT, d);        chk(d == 12'h000, "R3 cleared at third edge", int'(d), 0);
    wr(wa(1, 3), 12'd7);
    rd(STAT, d);        chk(d == 12'h800, "R3 ch1 duty pending bit 11", int'(d), 12'h800);
    poll();

    // R2: empty slots and read-only status
    wr(wa(2, 2), 12'hFFF);
    rd(STAT, d);        chk(d == 12'h000, "R2 slot write raised no pending", int'(d), 0);
    rd(wa(2, 2), d);    chk(d == 12'h000, "R2 slot reads zero", int'(d), 0);
    wr(STAT, 12'hFFF);
    rd(STAT, d);        chk(d == 12'h000, "R2 status not writable", int'(d), 0);

    // R5: idle level with inversion
    wr(wa(1, 0), 12'h002); poll();
    @(negedge clk);
    chk(pwm_out[1] == 1'b1, "R5 inverted idle level", int'(pwm_out[1]), 1);
    wr(wa(1, 0), 12'h000); poll();

    // R4 / R5 / R1: vector table
    for (int v = 0; v < NV; v++) begin
      automatic int         ch  = int'(VEC[v][67]);
      automatic logic       inv = VEC[v][66];
      automatic logic [11:0] duty = VEC[v][43:32];
      wr(wa(ch, 0), 12'h008); poll();
      wr(wa(ch, 1), 12'(VEC[v][65:56]));
      wr(wa(ch, 2), VEC[v][55:44]);
      wr(wa(ch, 3), duty);
      wr(wa(ch, 0), 12'h005 | (12'(inv) << 1)); poll();
      rd(wa(ch, 3), d);
      chk(d == duty, "R1 duty readback", int'(d), int'(duty));
      measure(ch, inv, hi, lo);
      chk(hi == int'(VEC[v][31:16]), "R4/R5 active time", hi, int'(VEC[v][31:16]));
      chk(lo == int'(VEC[v][15:0]),  "R4/R5 inactive time", lo, int'(VEC[v][15:0]));
    end
    wr(wa(1, 0), 12'h008); poll();

    // R6: duty extremes on ch0
    wr(wa(0, 0), 12'h008); poll();
    wr(wa(0, 1), 12'd0); wr(wa(0, 2), 12'd9); wr(wa(0, 3), 12'd0);
    wr(wa(0, 0), 12'h005); poll();
    count_active(0, 40, ones);
    chk(ones == 0, "R6 duty zero stays inactive", ones, 0);
    wr(wa(0, 3), 12'd12); poll();
    repeat (15) @(negedge clk);
    count_active(0, 40, ones);
    chk(ones == 40, "R6 duty above period stays active", ones, 40);

    // R7 / R8: reload behaviour on ch0
    wr(wa(0, 0), 12'h008); poll();
    wr(wa(0, 1), 12'd0); wr(wa(0, 2), 12'd19); wr(wa(0, 3), 12'd5);
    wr(wa(0, 0), 12'h001); poll();
    measure(0, 1'b0, hi, lo);
    chk(hi == 5 && lo == 15, "R7 baseline cycle", hi * 100 + lo, 515);
    wr(wa(0, 3), 12'd15); poll();
    measure(0, 1'b0, hi, lo);
    chk(hi == 5, "R7 duty held without autoload", hi, 5);
    wr(wa(0, 2), 12'd39); poll();
    measure(0, 1'b0, hi, lo);
    chk(lo == 15, "R7 period held without autoload", lo, 15);
    wr(wa(0, 0), 12'h021); poll();
    measure(0, 1'b0, hi, lo);
    chk(lo == 35, "R8 forced period load", lo, 35);
    chk(hi == 5, "R8 forced load leaves duty", hi, 5);
    wr(wa(0, 0), 12'h005); poll();
    measure(0, 1'b0, hi, lo);
    chk(hi == 15, "R7 autoload takes new duty", hi, 15);

    // R9: deferred and immediate stop
    wr(wa(0, 0), 12'h008); poll();
    wr(wa(0, 1), 12'd0); wr(wa(0, 2), 12'd99); wr(wa(0, 3), 12'd99);
    wr(wa(0, 0), 12'h001); poll();
    wait_rise(0, 1'b0);
    wr(wa(0, 0), 12'h000);
    repeat (4) @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R9 deferred stop keeps cycle", int'(pwm_out[0]), 1);
    repeat (105) @(negedge clk);
    count_active(0, 120, ones);
    chk(ones == 0, "R9 idle after cycle end", ones, 0);
    wr(wa(0, 0), 12'h001); poll();
    wait_rise(0, 1'b0);
    wr(wa(0, 0), 12'h008);
    repeat (4) @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R9 immediate stop", int'(pwm_out[0]), 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #900000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule